// File: doc/BRIEF.md
# Glitch-Filtered Reset Synchronizer

This block turns a raw reset request, which may come from a pin, a supervisor chip or another unrelated source and may carry noise, into a reset that is fully synchronous to one destination clock. The request passes through a capture flop and then a window of `STAGES` flops, all clocked by the destination clock. The output reset asserts only when every flop in the window holds an active sample. It releases as soon as any sample in the window is inactive. A request must therefore be sampled active on `STAGES` consecutive rising edges before it has any effect. Short glitches, runt pulses and pulses that fall between two clock edges are rejected.

Each clock domain gets its own instance. The polarity of the raw request and the polarity of the produced reset are each set by a parameter. A separate active-low power-on clear, `por_n`, brings every flop to the inactive state, so no reset is produced until a valid request arrives. The raw request itself is never used as an asynchronous control on any flop. Raising `STAGES` by one raises the shortest accepted request by one clock period.

Top module: `rstf_top`

## Requirements
- R1: While `por_n` is low, `rst_sync` is at its inactive level whatever `rst_req_raw` does. After `por_n` rises, `rst_sync` stays inactive until a request of the full qualifying length has been sampled.
- R2: If the request is sampled active on `STAGES` consecutive rising edges of `clk`, `rst_sync` becomes active on the second rising edge after the last of those samples.
- R3: A request sampled active on fewer than `STAGES` consecutive rising edges never makes `rst_sync` active.
- R4: A request pulse that rises and falls between two rising edges of `clk` is not sampled and has no effect on `rst_sync`.
- R5: Once active, `rst_sync` returns to inactive on the second rising edge after the first inactive sample of the request.
- R6: After a release, or after any inactive sample that breaks a run, a new assertion needs a fresh run of `STAGES` consecutive active samples. Active samples taken before the break do not count.
- R7: With `REQ_ACTIVE_LOW` = 1 the raw request is active when low, otherwise when high. With `OUT_ACTIVE_LOW` = 1 `rst_sync` is driven low when active, otherwise high. Timing is the same in every combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination clock; every flop samples on its rising edge |
| por_n | input | 1 | Active-low power-on clear of all flops, released synchronously to `clk` |
| rst_req_raw | input | 1 | Raw reset request, asynchronous to `clk`, polarity set by `REQ_ACTIVE_LOW` |
| rst_sync | output | 1 | Filtered synchronous reset, polarity set by `OUT_ACTIVE_LOW` |

## Verification
The bench numbers rising edges from the release of `por_n` and records what the request was on each edge. The output after edge t is expected to be active exactly when the samples on edges t-2 down to t-1-`STAGES` were all active. Assertion is therefore due two edges after the last sample of a qualifying run, and release two edges after the first inactive sample. The bench changes the request and compares both instances, one with three stages and one with two stages and opposite polarities, at the falling edge that follows each rising edge. Pulses injected just after a rising edge must show no effect in any of the following cycles.

// File: rtl/rstf_pkg.sv
package rstf_pkg;

  // Smallest window: two flops are also needed for metastability settling.
  localparam int unsigned RSTF_MIN_STAGES = 2;

  // Converts between an internal active-high flag and a pin level.
  function automatic logic rstf_level(input logic act, input bit active_low);
    return active_low ? ~act : act;
  endfunction

endpackage

// File: rtl/rstf_capture.sv
module rstf_capture #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic raw,
  output logic cap
);
  import rstf_pkg::*;

  logic req_act;
  logic cap_d;
  logic cap_q;

  // Normalise the raw pin to an active-high request flag.
  always_comb begin
    req_act = rstf_level(raw, ACTIVE_LOW);
    cap_d   = req_act;
  end

  // First synchronizer flop: the raw request only reaches its D input.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cap_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
    end
  end

  assign cap = cap_q;

endmodule

// File: rtl/rstf_window.sv
module rstf_window #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);

  logic [DEPTH-1:0] win_d;
  logic [DEPTH-1:0] win_q;

  // Next state: each stage takes its upstream neighbour.
  always_comb begin
    win_d[0] = din;
    for (int k = 1; k < DEPTH; k++) begin
      win_d[k] = win_q[k-1];
    end
  end

  // One flop per window stage.
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        win_q[g] <= 1'b0;
      end else begin
        win_q[g] <= win_d[g];
      end
    end
  end

  assign taps = win_q;

endmodule

// File: rtl/rstf_qualify.sv
module rstf_qualify #(
  parameter int unsigned DEPTH          = 3,
  parameter bit          OUT_ACTIVE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [DEPTH-1:0] taps,
  output logic             out_act,
  output logic             rst_o
);
  import rstf_pkg::*;

  logic out_d;
  logic out_q;

  // Active only when every sample in the window is active.
  always_comb begin
    out_d = &taps;
  end

  // Output register keeps the produced reset free of gate glitches.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
    end
  end

  assign out_act = out_q;
  assign rst_o   = rstf_level(out_q, OUT_ACTIVE_LOW);

endmodule

// File: rtl/rstf_top.sv
module rstf_top #(
  parameter int unsigned STAGES         = 3,
  parameter bit          REQ_ACTIVE_LOW = 1'b1,
  parameter bit          OUT_ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_req_raw,
  output logic rst_sync
);
  import rstf_pkg::*;

  localparam int unsigned RUN_W = $clog2(STAGES + 1);

  if (STAGES < RSTF_MIN_STAGES) begin : g_bad_stages
    $error("rstf_top: STAGES below minimum");
  end

  logic              cap;
  logic [STAGES-1:0] taps;
  logic              out_act;

  rstf_capture #(
    .ACTIVE_LOW (REQ_ACTIVE_LOW)
  ) u_capture (
    .clk   (clk),
    .por_n (por_n),
    .raw   (rst_req_raw),
    .cap   (cap)
  );

  rstf_window #(
    .DEPTH (STAGES)
  ) u_window (
    .clk   (clk),
    .por_n (por_n),
    .din   (cap),
    .taps  (taps)
  );

  rstf_qualify #(
    .DEPTH          (STAGES),
    .OUT_ACTIVE_LOW (OUT_ACTIVE_LOW)
  ) u_qualify (
    .clk     (clk),
    .por_n   (por_n),
    .taps    (taps),
    .out_act (out_act),
    .rst_o   (rst_sync)
  );

  // Checker state: length of the current run of active captured samples,
  // saturating at STAGES.
  logic [RUN_W-1:0] run_cnt;
  logic [RUN_W-1:0] run_nxt;

  always_comb begin
    if (!cap) begin
      run_nxt = '0;
    end else if (run_cnt == RUN_W'(STAGES)) begin
      run_nxt = run_cnt;
    end else begin
      run_nxt = run_cnt + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_cnt <= '0;
    end else begin
      run_cnt <= run_nxt;
    end
  end

  AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!por_n)
    $rose(out_act) |-> ($past(run_cnt) == RUN_W'(STAGES))); // R2

  AST_FULL_RUN_ASSERTS: assert property (@(posedge clk) disable iff (!por_n)
    (run_cnt == RUN_W'(STAGES)) |=> out_act); // R2

  AST_SHORT_RUN_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    (!out_act && (run_cnt < RUN_W'(STAGES))) |=> !out_act); // R3

  AST_BREAK_RELEASES: assert property (@(posedge clk) disable iff (!por_n)
    (run_cnt == '0) |=> !out_act); // R5

endmodule

// File: tb/sim_rstf_top.sv
module sim_rstf_top;

  localparam int CLK_PERIOD = 10;
  localparam int N0         = 3;
  localparam int N1         = 2;
  localparam int MAXT       = 8192;

  logic clk;
  logic por_n;
  logic req;
  logic raw0;
  logic raw1;
  logic out0;
  logic out1;

  bit   samp [MAXT];
  int   t;
  int   checks;
  int   errors;
  bit   done;
  bit   prev0;

  assign raw0 = ~req;  // u0 request is active low
  assign raw1 = req;   // u1 request is active high

  rstf_top #(.STAGES(N0), .REQ_ACTIVE_LOW(1'b1), .OUT_ACTIVE_LOW(1'b0)) u0 (
    .clk(clk), .por_n(por_n), .rst_req_raw(raw0), .rst_sync(out0));

  rstf_top #(.STAGES(N1), .REQ_ACTIVE_LOW(1'b0), .OUT_ACTIVE_LOW(1'b1)) u1 (
    .clk(clk), .por_n(por_n), .rst_req_raw(raw1), .rst_sync(out1));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Expected active flag after edge tt: samples tt-2 .. tt-1-n all active.
  function automatic bit expect_act(int n, int tt);
    for (int j = 0; j < n; j++) begin
      int idx = tt - 2 - j;
      if (idx < 1) return 1'b0;
      if (!samp[idx]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(string tag, string who, logic act, logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s edge=%0d actual=%b expected=%b", tag, who, t, act, exp_v);
    end
  endtask

  // One cycle: drive at the falling edge, sample at the next falling edge.
  task automatic step(bit b, bit glitch, string idle_tag);
    bit e0;
    bit e1;
    string tag;
    req = b;
    @(posedge clk);
    t++;
    samp[t] = b;
    if (glitch) begin
      #1 req = 1'b1;
      #2 req = 1'b0;
    end
    @(negedge clk);
    e0 = expect_act(N0, t);
    e1 = expect_act(N1, t);
    if (e0 != prev0) tag = e0 ? "R2" : "R5";
    else             tag = idle_tag;
    check(tag, "u0", out0, e0);
    check("R7", "u1", out1, ~e1);
    prev0 = e0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    prev0  = 1'b0;
    t      = 0;
    por_n  = 1'b0;
    req    = 1'b0;

    // R1: power-on clear holds outputs inactive, even with a live request.
    repeat (2) @(negedge clk);
    req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1", "u0", out0, 1'b0);
      check("R1", "u1", out1, 1'b1);
    end
    req   = 1'b0;
    por_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R1");

    // R2 R3 R5: single pulses of every length around the thresholds.
    for (int len = 0; len <= N0 + 4; len++) begin
      for (int i = 0; i < len; i++) step(1'b1, 1'b0, "R3");
      for (int i = 0; i < 6; i++)   step(1'b0, 1'b0, "R3");
    end

    // R6: every 8-bit noise pattern; broken runs must restart the count.
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < 8; i++) step(p[i], 1'b0, "R6");
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R6");
    end

    // R4: pulses placed between edges are never sampled.
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, "R4");

    // R4 R6: a between-edge pulse cannot bridge a gap in a run.
    for (int i = 0; i < N0 - 1; i++) step(1'b1, 1'b0, "R6");
    step(1'b0, 1'b1, "R4");
    for (int i = 0; i < N0 - 1; i++) step(1'b1, 1'b0, "R6");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R6");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule